// File: doc/BRIEF.md
# CPU Interrupt Control Unit

This block keeps the interrupt state of an 8-bit processor core. It holds two interrupt-enable flags and an interrupt-mode register. It watches a non-maskable request line and a level-sensitive maskable request line. It decides at the start of each opcode fetch whether an interrupt is taken. The instruction decoder drives its control pins, and the sequencer reads its flag, mode and acceptance outputs.

The primary enable flag (`ief1`) gates maskable requests. The shadow flag (`ief2`) keeps a copy of the primary flag while a non-maskable service routine runs. A write to both flags reaches the shadow flag first and the primary flag one clock later, so interrupts are enabled with a delay. A single-flag write changes only the primary flag, which lets the core restore it from the shadow at the end of a service routine.

The non-maskable line is edge-detected and held as a pending request until it is taken. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `intr_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ief1`, `ief2`, `mode1`, `mode2`, `nmi_active` and `irq_active` are all 0 (mode 0).
- R2: With `mode_we` high, the next clock edge loads the mode from `mode_code`: 2'b00 and 2'b01 give mode 0 (`mode1`=0, `mode2`=0), 2'b10 gives mode 1 (`mode1`=1, `mode2`=0), and 2'b11 gives mode 2 (`mode1`=0, `mode2`=1).
- R3: With `mode_we` low, the mode outputs keep their value whatever `mode_code` carries.
- R4: A flag write with `flag_we`=1 and `flag_both`=1 sets `ief2` to `flag_val` at the next edge and sets `ief1` to the same value at the edge after that.
- R5: A flag write with `flag_both`=0 sets `ief1` to `flag_val` at the next edge and leaves `ief2` unchanged.
- R6: A rising edge on `nmi_req` becomes a pending request. At an edge where `fetch_start` is high and a request is pending, the request is taken: `ief1` becomes 0, `ief2` keeps its value, and `nmi_active` becomes 1.
- R7: One rising edge on `nmi_req` gives exactly one acceptance, even if the line stays high.
- R8: At an edge where `fetch_start` is high, `irq_req` is high, `ief1` is 1, no non-maskable request is pending and `int_inhibit` is low, the maskable request is taken: both flags become 0 and `irq_active` becomes 1.
- R9: A maskable request is not taken when `ief1` is 0 or `int_inhibit` is high. In that case both flags and `irq_active` keep the values they would otherwise have.
- R10: When a non-maskable request is pending at the same `fetch_start` as a valid maskable request, only the non-maskable request is taken.
- R11: `nmi_active` and `irq_active` hold from acceptance until the next edge with `fetch_start` high. At that edge each one drops unless a new acceptance of that kind occurs.
- R12: An acceptance overrides a flag write at the same edge and cancels a pending delayed update of `ief1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load the interrupt mode from mode_code |
| mode_code | input | 2 | Mode code from the data bus |
| flag_we | input | 1 | Enable flag write |
| flag_val | input | 1 | Value written to the enable flags |
| flag_both | input | 1 | 1: write both flags (delayed primary); 0: primary only |
| int_inhibit | input | 1 | Blocks acceptance of maskable requests |
| nmi_req | input | 1 | Non-maskable request, edge-sensitive |
| irq_req | input | 1 | Maskable request, level-sensitive |
| fetch_start | input | 1 | Start of an opcode-fetch cycle |
| ief1 | output | 1 | Primary interrupt-enable flag |
| ief2 | output | 1 | Shadow interrupt-enable flag |
| mode1 | output | 1 | Mode 1 selected |
| mode2 | output | 1 | Mode 2 selected |
| nmi_active | output | 1 | Non-maskable request taken |
| irq_active | output | 1 | Maskable request taken |

## Verification
The mode register is swept over every code, with the write enable both high and low. This separates the code decode from the hold behaviour. Every combination of write select and value is applied from each starting flag pair, which shows the one-edge shadow update apart from the two-edge primary update. The acceptance logic is swept over the primary flag, inhibit, maskable level and a pending non-maskable request in all combinations. This exposes wrong gating and wrong priority in a single pass. Dedicated sequences cover a held non-maskable line, the hold-then-clear of the active outputs, and a flag write that collides with an acceptance.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    IMODE_0 = 2'd0,
    IMODE_1 = 2'd1,
    IMODE_2 = 2'd2
  } imode_e;

  function automatic imode_e decode_mode(input logic [CODE_W-1:0] code);
    imode_e m;
    unique case (code)
      2'b10:   m = IMODE_1;
      2'b11:   m = IMODE_2;
      default: m = IMODE_0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/intr_mode_reg.sv
module intr_mode_reg
  import intr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] code,
  output logic              is_m1,
  output logic              is_m2
);
  imode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  mode_q <= IMODE_0;
    else if (we) mode_q <= decode_mode(code);
  end

  assign is_m1 = (mode_q == IMODE_1);
  assign is_m2 = (mode_q == IMODE_2);
endmodule

// File: rtl/intr_enable_flags.sv
module intr_enable_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic wr_both,
  input  logic take_any,
  input  logic take_mask,
  output logic ief1,
  output logic ief2
);
  logic ief1_q, ief2_q;
  logic dly_q, dly_val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ief1_q    <= 1'b0;
      ief2_q    <= 1'b0;
      dly_q     <= 1'b0;
      dly_val_q <= 1'b0;
    end else if (take_any) begin
      // acceptance wins over any write and drops a delayed update
      ief1_q    <= 1'b0;
      dly_q     <= 1'b0;
      dly_val_q <= 1'b0;
      if (take_mask) ief2_q <= 1'b0;
    end else begin
      if (wr_en && !wr_both) ief1_q <= wr_val;
      else if (dly_q)        ief1_q <= dly_val_q;
      if (wr_en && wr_both)  ief2_q <= wr_val;
      dly_q     <= wr_en && wr_both;
      dly_val_q <= wr_val;
    end
  end

  assign ief1 = ief1_q;
  assign ief2 = ief2_q;
endmodule

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic taken,
  output logic pending
);
  logic prev_q, pend_q;
  logic rise;

  assign rise = line && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line;
      pend_q <= (pend_q && !taken) || rise;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  input  logic nmi_pend,
  input  logic irq_lvl,
  input  logic ief1,
  input  logic inhibit,
  output logic take_nmi,
  output logic take_irq,
  output logic nmi_act,
  output logic irq_act
);
  logic nmi_act_q, irq_act_q;

  assign take_nmi = fetch && nmi_pend;
  assign take_irq = fetch && !nmi_pend && irq_lvl && ief1 && !inhibit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_act_q <= 1'b0;
      irq_act_q <= 1'b0;
    end else if (fetch) begin
      nmi_act_q <= take_nmi;
      irq_act_q <= take_irq;
    end
  end

  assign nmi_act = nmi_act_q;
  assign irq_act = irq_act_q;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              flag_we,
  input  logic              flag_val,
  input  logic              flag_both,
  input  logic              int_inhibit,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              fetch_start,
  output logic              ief1,
  output logic              ief2,
  output logic              mode1,
  output logic              mode2,
  output logic              nmi_active,
  output logic              irq_active
);
  logic nmi_pend, take_nmi, take_irq;

  intr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .code(mode_code),
    .is_m1(mode1), .is_m2(mode2)
  );

  intr_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .line(nmi_req), .taken(take_nmi),
    .pending(nmi_pend)
  );

  intr_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .fetch(fetch_start), .nmi_pend(nmi_pend),
    .irq_lvl(irq_req), .ief1(ief1), .inhibit(int_inhibit),
    .take_nmi(take_nmi), .take_irq(take_irq),
    .nmi_act(nmi_active), .irq_act(irq_active)
  );

  intr_enable_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(flag_we), .wr_val(flag_val),
    .wr_both(flag_both), .take_any(take_nmi || take_irq),
    .take_mask(take_irq), .ief1(ief1), .ief2(ief2)
  );
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_we,
  input logic [1:0] mode_code,
  input logic       flag_we,
  input logic       flag_val,
  input logic       flag_both,
  input logic       int_inhibit,
  input logic       fetch_start,
  input logic       ief1,
  input logic       ief2,
  input logic       mode1,
  input logic       mode2,
  input logic       nmi_active,
  input logic       irq_active
);
  // R2
  mode_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && mode_code == 2'b10 |=> mode1 && !mode2);
  // R2
  mode_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && mode_code == 2'b11 |=> !mode1 && mode2);
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode1) && $stable(mode2));
  // R4
  shadow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && flag_both && !fetch_start |=> ief2 == $past(flag_val));
  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && !flag_both && !fetch_start |=> $stable(ief2) && ief1 == $past(flag_val));
  // R4
  ief1_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ief1) |-> $past(flag_we && !flag_both && flag_val)
                    || $past(flag_we && flag_both && flag_val, 2));
  // R6
  nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_active) |-> !ief1 && ief2 == $past(ief2));
  // R8
  irq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_active) |-> !ief1 && !ief2 && $past(ief1) && !$past(int_inhibit));
  // R10
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_active, irq_active}));
  // R11
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_start |=> $stable(nmi_active) && $stable(irq_active));
endmodule

bind intr_ctrl intr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
  .flag_we(flag_we), .flag_val(flag_val), .flag_both(flag_both),
  .int_inhibit(int_inhibit), .fetch_start(fetch_start),
  .ief1(ief1), .ief2(ief2), .mode1(mode1), .mode2(mode2),
  .nmi_active(nmi_active), .irq_active(irq_active)
);

// File: tb/intr_ctrl_tb.sv
`timescale 1ns/1ps
module intr_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, flag_we = 0, flag_val = 0, flag_both = 0;
  logic int_inhibit = 0, nmi_req = 0, irq_req = 0, fetch_start = 0;
  logic [1:0] mode_code = 2'b00;
  logic ief1, ief2, mode1, mode2, nmi_active, irq_active;
  int checks = 0, failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
    .flag_we(flag_we), .flag_val(flag_val), .flag_both(flag_both),
    .int_inhibit(int_inhibit), .nmi_req(nmi_req), .irq_req(irq_req),
    .fetch_start(fetch_start), .ief1(ief1), .ief2(ief2), .mode1(mode1),
    .mode2(mode2), .nmi_active(nmi_active), .irq_active(irq_active)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_we = 0; flag_we = 0; flag_val = 0; flag_both = 0;
    int_inhibit = 0; nmi_req = 0; irq_req = 0; fetch_start = 0; mode_code = 0;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; step(); step(); rst_n = 1;
  endtask

  // both-flag write of b, then single write of a
  task automatic set_flags(input logic a, input logic b);
    flag_we = 1; flag_both = 1; flag_val = b; step();
    flag_we = 0; step();
    flag_we = 1; flag_both = 0; flag_val = a; step();
    flag_we = 0; flag_val = 0;
  endtask

  task automatic pulse_nmi();
    nmi_req = 1; step(); nmi_req = 0; step();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset values
    chk("R1 ief1", ief1, 0); chk("R1 ief2", ief2, 0);
    chk("R1 mode", {mode1, mode2}, 0);
    chk("R1 active", {nmi_active, irq_active}, 0);

    // R2 / R3: sweep codes with write enable on, then off
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        int em1, em2;
        mode_we = 1; mode_code = 2'(c); step();
        em1 = (c == 2) ? 1 : 0; em2 = (c == 3) ? 1 : 0;
        chk("R2 mode1", mode1, em1); chk("R2 mode2", mode2, em2);
        mode_we = 0; mode_code = 2'(p); step();
        chk("R3 mode1 hold", mode1, em1); chk("R3 mode2 hold", mode2, em2);
      end
    end
    idle();

    // R4 / R5: flag write sweep from every start pair
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        logic s1, s2, both, v;
        s1 = s[1]; s2 = s[0]; both = w[1]; v = w[0];
        do_reset(); set_flags(s1, s2); step();
        chk("R4 setup ief1", ief1, s1); chk("R4 setup ief2", ief2, s2);
        flag_we = 1; flag_both = both; flag_val = v; step();
        idle();
        if (both) begin
          chk("R4 ief2 first edge", ief2, v);
          chk("R4 ief1 not yet", ief1, s1);
          step();
          chk("R4 ief1 second edge", ief1, v);
        end else begin
          chk("R5 ief1", ief1, v);
          chk("R5 ief2 kept", ief2, s2);
        end
      end
    end

    // R6 / R8 / R9 / R10 / R11: acceptance sweep
    for (int k = 0; k < 16; k++) begin
      logic f1, inh, irq, np, itake;
      f1 = k[3]; inh = k[2]; irq = k[1]; np = k[0];
      do_reset(); set_flags(f1, 1'b1); step();
      if (np) pulse_nmi();
      irq_req = irq; int_inhibit = inh; fetch_start = 1; step();
      idle();
      itake = !np && irq && f1 && !inh;
      chk("R6 R10 nmi_active", nmi_active, np);
      chk("R8 R9 R10 irq_active", irq_active, itake);
      chk("R6 R8 R9 ief1", ief1, (np || itake) ? 0 : f1);
      chk("R6 R8 R9 ief2", ief2, itake ? 0 : 1);
      step();
      chk("R11 hold", {nmi_active, irq_active}, {np, itake});
      fetch_start = 1; step(); idle();
      chk("R11 clear", {nmi_active, irq_active}, 0);
    end

    // R7: held line yields one acceptance
    do_reset(); set_flags(1, 1); step();
    nmi_req = 1; step(); fetch_start = 1; step();
    chk("R7 first take", nmi_active, 1);
    step();
    chk("R7 no second take", nmi_active, 0);
    chk("R7 ief1 stays", ief1, 0);
    idle(); step();

    // R12: collision of both-flag write with an acceptance
    do_reset(); pulse_nmi();
    flag_we = 1; flag_both = 1; flag_val = 1; fetch_start = 1; step();
    idle();
    chk("R12 nmi taken", nmi_active, 1);
    chk("R12 ief2 kept", ief2, 0);
    step();
    chk("R12 delayed ief1 cancelled", ief1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule